// File: doc/BRIEF.md
# Interleaved Cache Line Refill Controller

This block services a cache miss by loading one cache line from a memory made of one-word-wide banks, one bank for each word of the line. All banks are read at once, so the line costs one address phase and one bank access, followed by one data transfer per word. The word that missed is returned first. The other words follow in wrap-around order, so the processor can restart on the missed word before the line is complete.

A miss is presented as a line address plus the offset of the word that missed. The controller drives the bank address and a bank-enable window, and latches every bank's word at the end of the access. It then sends the words one per transfer slot through a write port that carries the word's slot index, so the cache writes each word into the right place. A data-ready strobe gives the processor the missed word on the first beat. A completion pulse marks the last word. With the default timing (4-cycle address phase, 24-cycle access, 4 cycles per word, 4 words) a refill takes 4 + 24 + 4×4 = 44 cycles.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: After reset, `busy`, `bank_en`, `fill_we`, `cpu_rdy` and `line_done` are all low.
- R2: A request (`miss_req` high while `busy` is low) is taken at a rising clock edge. `busy` is high from that edge until the edge that raises `line_done`, and falls at that edge.
- R3: `bank_en` is high for exactly ACCESS_CYC cycles, starting ADDR_CYC cycles after the accept edge. While `bank_en` is high, `bank_addr` equals the accepted line address.
- R4: The first `fill_we` pulse comes ADDR_CYC + ACCESS_CYC + XFER_CYC cycles after the accept edge. It carries `fill_off` equal to the requested offset and the word read from the bank with that index.
- R5: `cpu_rdy` pulses exactly once per refill, in the same cycle as the first fill word. `cpu_data` then equals the missed word.
- R6: Beat k (k = 0..3) comes XFER_CYC·k cycles after the first beat, with `fill_off` = (requested offset + k) mod 4 and `fill_data` equal to bank `fill_off`'s word. `fill_we` is low in every other cycle.
- R7: `line_done` is a single-cycle pulse, high in the same cycle as the fourth fill word. This is ADDR_CYC + ACCESS_CYC + 4·XFER_CYC = 44 cycles after the accept edge.
- R8: A `miss_req` raised while `busy` is high is ignored. The refill in progress keeps its line address, offset order, data and timing.
- R9: A request held high through the `line_done` cycle is taken at the next rising edge, and the new refill runs with the R3 to R7 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_req | input | 1 | Miss request |
| miss_blk_addr | input | 28 | Line address of the miss |
| miss_off | input | 2 | Word offset that missed |
| busy | output | 1 | Refill in progress |
| bank_en | output | 1 | Bank access window |
| bank_addr | output | 28 | Line address sent to all banks |
| bank_rdata | input | 128 | Bank k's word at bits [32k+31:32k] |
| fill_we | output | 1 | Cache fill write strobe |
| fill_off | output | 2 | Word slot of the fill word |
| fill_data | output | 32 | Fill word |
| cpu_rdy | output | 1 | Missed word ready for the processor |
| cpu_data | output | 32 | Missed word |
| line_done | output | 1 | Line fully loaded |

## Verification
Refills are started at random line addresses, and directed cases cover all four offsets. Offsets 0 and 3 separate a correct wrap (3, 0, 1, 2) from linear or reversed ordering, and random line addresses give every bank a distinct word, so a bank-to-slot mix-up shows. Extra requests injected while busy, with a different address and offset, separate a controller that ignores them from one that reloads its address or offset. A request held high across `line_done` measures the restart edge exactly.

// File: rtl/ilv_refill_pkg.sv
package ilv_refill_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_ADDR   = 2'd1,
      PH_ACCESS = 2'd2,
      PH_XFER   = 2'd3
   } phase_e;

   // width of a counter able to hold values 0..n-1, never below one bit
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/ilv_refill_timer.sv
module ilv_refill_timer
   import ilv_refill_pkg::*;
#(
   parameter int unsigned ADDR_CYC   = 4,
   parameter int unsigned ACCESS_CYC = 24,
   parameter int unsigned XFER_CYC   = 4,
   parameter int unsigned NUM_BEATS  = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   output phase_e                         phase_o,
   output logic                           capture_o,
   output logic                           beat_tick_o,
   output logic [$clog2(NUM_BEATS)-1:0]   beat_o,
   output logic                           last_o
);

   localparam int unsigned CNT_W  = cnt_width(max3(ADDR_CYC, ACCESS_CYC, XFER_CYC));
   localparam int unsigned BEAT_W = $clog2(NUM_BEATS);
   localparam logic [CNT_W-1:0]  ADDR_LD  = CNT_W'(ADDR_CYC - 1);
   localparam logic [CNT_W-1:0]  ACC_LD   = CNT_W'(ACCESS_CYC - 1);
   localparam logic [CNT_W-1:0]  XFER_LD  = CNT_W'(XFER_CYC - 1);
   localparam logic [BEAT_W-1:0] BEAT_END = BEAT_W'(NUM_BEATS - 1);

   phase_e            phase_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BEAT_W-1:0] beat_q;
   logic              cnt_zero;

   assign cnt_zero    = (cnt_q == '0);
   assign phase_o     = phase_q;
   assign capture_o   = (phase_q == PH_ACCESS) && cnt_zero;
   assign beat_tick_o = (phase_q == PH_XFER) && cnt_zero;
   assign beat_o      = beat_q;
   assign last_o      = beat_tick_o && (beat_q == BEAT_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         beat_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (start_i) begin
                  phase_q <= PH_ADDR;
                  cnt_q   <= ADDR_LD;
               end
            end
            PH_ADDR: begin
               if (cnt_zero) begin
                  phase_q <= PH_ACCESS;
                  cnt_q   <= ACC_LD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_ACCESS: begin
               if (cnt_zero) begin
                  phase_q <= PH_XFER;
                  cnt_q   <= XFER_LD;
                  beat_q  <= '0;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_XFER: begin
               if (cnt_zero) begin
                  if (beat_q == BEAT_END) begin
                     phase_q <= PH_IDLE;
                     beat_q  <= '0;
                  end else begin
                     beat_q <= beat_q + 1'b1;
                     cnt_q  <= XFER_LD;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ilv_refill_bank_latch.sv
module ilv_refill_bank_latch #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_BANKS = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 capture_i,
   input  logic [NUM_BANKS*WORD_W-1:0]          bank_rdata_i,
   output logic [NUM_BANKS-1:0][WORD_W-1:0]     words_o
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         word_q <= '0;
         else if (capture_i) word_q <= bank_rdata_i[b*WORD_W +: WORD_W];
      end
      assign words_o[b] = word_q;
   end

endmodule

// File: rtl/ilv_refill_word_sel.sv
module ilv_refill_word_sel #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_BANKS = 4
) (
   input  logic [NUM_BANKS-1:0][WORD_W-1:0]     words_i,
   input  logic [$clog2(NUM_BANKS)-1:0]         crit_off_i,
   input  logic [$clog2(NUM_BANKS)-1:0]         beat_i,
   output logic [$clog2(NUM_BANKS)-1:0]         slot_o,
   output logic [WORD_W-1:0]                    word_o
);

   // power-of-two bank count: the offset sum wraps by truncation
   assign slot_o = crit_off_i + beat_i;

   always_comb begin
      word_o = '0;
      for (int i = 0; i < NUM_BANKS; i++) begin
         if (slot_o == i[$clog2(NUM_BANKS)-1:0]) word_o = words_i[i];
      end
   end

endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl
   import ilv_refill_pkg::*;
#(
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned NUM_BANKS  = 4,
   parameter int unsigned BLK_ADDR_W = 28,
   parameter int unsigned ADDR_CYC   = 4,
   parameter int unsigned ACCESS_CYC = 24,
   parameter int unsigned XFER_CYC   = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              miss_req,
   input  logic [BLK_ADDR_W-1:0]             miss_blk_addr,
   input  logic [$clog2(NUM_BANKS)-1:0]      miss_off,
   output logic                              busy,
   output logic                              bank_en,
   output logic [BLK_ADDR_W-1:0]             bank_addr,
   input  logic [NUM_BANKS*WORD_W-1:0]       bank_rdata,
   output logic                              fill_we,
   output logic [$clog2(NUM_BANKS)-1:0]      fill_off,
   output logic [WORD_W-1:0]                 fill_data,
   output logic                              cpu_rdy,
   output logic [WORD_W-1:0]                 cpu_data,
   output logic                              line_done
);

   localparam int unsigned OFF_W = $clog2(NUM_BANKS);

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (ADDR_CYC < 1 || ACCESS_CYC < 1 || XFER_CYC < 1) begin : g_bad_timing
      $error("all phase lengths must be at least one cycle");
   end
   if (WORD_W < 1 || BLK_ADDR_W < 1) begin : g_bad_width
      $error("word and address widths must be positive");
   end

   phase_e                          phase;
   logic                            accept;
   logic                            capture;
   logic                            beat_tick;
   logic                            last_beat;
   logic [OFF_W-1:0]                beat;
   logic [OFF_W-1:0]                crit_off_q;
   logic [BLK_ADDR_W-1:0]           blk_addr_q;
   logic [NUM_BANKS-1:0][WORD_W-1:0] words;
   logic [OFF_W-1:0]                slot;
   logic [WORD_W-1:0]               slot_word;

   assign busy   = (phase != PH_IDLE);
   assign accept = miss_req && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_addr_q <= '0;
         crit_off_q <= '0;
      end else if (accept) begin
         blk_addr_q <= miss_blk_addr;
         crit_off_q <= miss_off;
      end
   end

   ilv_refill_timer #(
      .ADDR_CYC   (ADDR_CYC),
      .ACCESS_CYC (ACCESS_CYC),
      .XFER_CYC   (XFER_CYC),
      .NUM_BEATS  (NUM_BANKS)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (accept),
      .phase_o     (phase),
      .capture_o   (capture),
      .beat_tick_o (beat_tick),
      .beat_o      (beat),
      .last_o      (last_beat)
   );

   assign bank_en   = (phase == PH_ACCESS);
   assign bank_addr = blk_addr_q;

   ilv_refill_bank_latch #(
      .WORD_W    (WORD_W),
      .NUM_BANKS (NUM_BANKS)
   ) u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .capture_i    (capture),
      .bank_rdata_i (bank_rdata),
      .words_o      (words)
   );

   ilv_refill_word_sel #(
      .WORD_W    (WORD_W),
      .NUM_BANKS (NUM_BANKS)
   ) u_sel (
      .words_i    (words),
      .crit_off_i (crit_off_q),
      .beat_i     (beat),
      .slot_o     (slot),
      .word_o     (slot_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_we   <= 1'b0;
         fill_off  <= '0;
         fill_data <= '0;
         cpu_rdy   <= 1'b0;
         cpu_data  <= '0;
         line_done <= 1'b0;
      end else begin
         fill_we   <= beat_tick;
         line_done <= last_beat;
         cpu_rdy   <= beat_tick && (beat == '0);
         if (beat_tick) begin
            fill_off  <= slot;
            fill_data <= slot_word;
         end
         if (beat_tick && (beat == '0)) cpu_data <= slot_word;
      end
   end

endmodule

// File: rtl/ilv_refill_chk.sv
module ilv_refill_chk #(
   parameter int unsigned XFER_CYC = 4
) (
   input logic clk,
   input logic rst_n,
   input logic miss_req,
   input logic busy,
   input logic bank_en,
   input logic fill_we,
   input logic cpu_rdy,
   input logic line_done
);

   // R2
   accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req && !busy) |=> busy);

   // R2
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> !busy);

   // R5
   cpu_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdy |-> fill_we);

   // R7
   done_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> (fill_we && !cpu_rdy));

   // R6
   fill_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((XFER_CYC > 1) && fill_we) |=> !fill_we);

   // R3
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_en |-> (!fill_we && busy));

endmodule

bind ilv_refill_ctrl ilv_refill_chk #(
   .XFER_CYC (XFER_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .miss_req  (miss_req),
   .busy      (busy),
   .bank_en   (bank_en),
   .fill_we   (fill_we),
   .cpu_rdy   (cpu_rdy),
   .line_done (line_done)
);

// File: tb/tb_ilv_refill_ctrl.sv
module tb_ilv_refill_ctrl;

   localparam int WORD_W = 32;
   localparam int NB     = 4;
   localparam int AW     = 28;
   localparam int T_ADDR = 4;
   localparam int T_ACC  = 24;
   localparam int T_XFER = 4;
   localparam int T_LINE = T_ADDR + T_ACC + NB * T_XFER;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              miss_req = 1'b0;
   logic [AW-1:0]     miss_blk_addr = '0;
   logic [1:0]        miss_off = '0;
   logic              busy, bank_en, fill_we, cpu_rdy, line_done;
   logic [AW-1:0]     bank_addr;
   logic [NB*WORD_W-1:0] bank_rdata;
   logic [1:0]        fill_off;
   logic [WORD_W-1:0] fill_data, cpu_data;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   ilv_refill_ctrl dut (
      .clk (clk), .rst_n (rst_n), .miss_req (miss_req),
      .miss_blk_addr (miss_blk_addr), .miss_off (miss_off),
      .busy (busy), .bank_en (bank_en), .bank_addr (bank_addr),
      .bank_rdata (bank_rdata), .fill_we (fill_we), .fill_off (fill_off),
      .fill_data (fill_data), .cpu_rdy (cpu_rdy), .cpu_data (cpu_data),
      .line_done (line_done)
   );

   function automatic logic [WORD_W-1:0] mem_word(input logic [AW-1:0] a, input int b);
      return ({4'h0, a} * 32'h9E37_79B1) ^ (32'h0101_0101 * (b + 1)) ^ 32'h5A00_00A5;
   endfunction

   // bank model: every bank returns its word of the addressed line
   always_comb begin
      for (int b = 0; b < NB; b++) bank_rdata[b*WORD_W +: WORD_W] = mem_word(bank_addr, b);
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // one refill; on return we stand at the negedge after the line_done edge
   task automatic refill(input logic [AW-1:0] a, input logic [1:0] off, input bit poke);
      logic [1:0] exp_off;
      int beat;
      miss_req = 1'b1; miss_blk_addr = a; miss_off = off;
      @(posedge clk);                       // accept edge
      @(negedge clk);
      miss_req = 1'b0;
      for (int t = 1; t <= T_LINE; t++) begin
         if (poke && t >= 8 && t < 20) begin      // R8 stimulus
            miss_req = 1'b1; miss_blk_addr = ~a; miss_off = off + 2'd1;
         end else begin
            miss_req = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         chk(busy == (t < T_LINE), "R2 busy", busy, t < T_LINE);
         chk(bank_en == (t >= T_ADDR && t < T_ADDR + T_ACC), "R3 bank_en", bank_en,
             t >= T_ADDR && t < T_ADDR + T_ACC);
         if (bank_en) chk(bank_addr == a, "R3 R8 bank_addr", bank_addr, a);
         beat = (t - T_ADDR - T_ACC) / T_XFER - 1;
         if (t > T_ADDR + T_ACC && (t - T_ADDR - T_ACC) % T_XFER == 0) begin
            exp_off = off + beat[1:0];
            chk(fill_we == 1'b1, "R6 fill_we high", fill_we, 1);
            chk(fill_off == exp_off, "R4 R6 fill_off", fill_off, exp_off);
            chk(fill_data == mem_word(a, exp_off), "R4 R6 R8 fill_data", fill_data,
                mem_word(a, exp_off));
            chk(cpu_rdy == (beat == 0), "R5 cpu_rdy", cpu_rdy, beat == 0);
            if (beat == 0) chk(cpu_data == mem_word(a, off), "R5 cpu_data", cpu_data,
                               mem_word(a, off));
            chk(line_done == (beat == NB - 1), "R7 line_done", line_done, beat == NB - 1);
         end else begin
            chk(!fill_we && !cpu_rdy && !line_done, "R6 R7 idle strobes",
                {fill_we, cpu_rdy, line_done}, 0);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!busy && !bank_en && !fill_we && !cpu_rdy && !line_done, "R1 reset state",
          {busy, bank_en, fill_we, cpu_rdy, line_done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy, "R1 idle after reset", busy, 0);
      // directed: every offset, incl. the wrap from 3
      for (int o = 0; o < NB; o++) refill(28'h0ABC_D00 + AW'(o), o[1:0], 1'b0);
      // requests while busy
      refill(28'h123_4567, 2'd3, 1'b1);
      refill(28'hFFF_FFFF, 2'd1, 1'b1);
      // R9: back-to-back, next request raised right after line_done
      refill(28'h000_0000, 2'd2, 1'b0);
      refill(28'h555_5555, 2'd3, 1'b0);
      // random traffic with idle gaps
      for (int n = 0; n < 20; n++) begin
         repeat ($urandom_range(0, 3)) begin
            @(negedge clk);
            chk(!busy && !fill_we, "R2 idle gap", {busy, fill_we}, 0);
         end
         refill(AW'($urandom), 2'($urandom), 1'($urandom));
      end
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule